// File: doc/BRIEF.md
# Programmable Test Pattern Sequencer

The sequencer sits between a converter's sample path and its output serializer. In normal operation it forwards each converter sample to the output. When the operation-mode field selects pattern output, it replaces those samples with known words, so that a downstream receiver can check link timing and bit connectivity against values it can predict.

Eight sequence slots each hold a 3-bit pattern code. On every sample clock in pattern mode the sequencer emits the word chosen by the current slot and moves to the next slot, wrapping from the last slot back to the first. Six codes select words fixed in hardware. One of these is a word that alternates between all ones and all zeros each time it is emitted. The remaining two codes select words taken from two user pattern inputs. The configuration reaches the block as plain register values. Writing those registers and serializing the output are handled elsewhere.

Top module: `tpseq_top`

## Requirements
- R1: While `rstN` is low, `dataOut` is 0 and `patActive` is 0.
- R2: When `modeSel` is not 2'b11, `dataOut` equals the `sampleIn` value from one clock earlier and `patActive` is 0.
- R3: When `modeSel` is 2'b11, `patActive` is 1 from the next clock onward.
- R4: The first word after pattern mode is entered comes from slot 0. Each later word comes from the next slot in the order 0,1,...,7,0, with one slot per clock.
- R5: Fixed codes give these words: 3'b000 → 0x0000, 3'b001 → 0xFFFF, 3'b011 → 0xAAAA, 3'b100 → 0x5555, 3'b101 → 0xA5A5.
- R6: Code 3'b010 gives 0xFFFF on its first emission after pattern mode is entered, then 0x0000, then 0xFFFF, and so on. Its phase advances only when that code is emitted. With every slot set to 3'b010, the output therefore alternates between all ones and all zeros.
- R7: Code 3'b110 emits `userPatA` and code 3'b111 emits `userPatB`, using the value sampled on the clock edge that registers the word.
- R8: Slot k reads its code from `slotCodes[3k+2:3k]`.
- R9: A change to a slot code or a user pattern takes effect the next time that slot is emitted. No copy of the configuration is taken when pattern mode is entered.
- R10: Leaving pattern mode and entering it again restarts the sequence at slot 0 and resets the phase of code 3'b010 to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Operation mode; 2'b11 selects pattern output |
| sampleIn | input | 16 | Converter sample to forward in normal mode |
| slotCodes | input | 24 | Eight 3-bit slot codes, slot k at bits 3k+2:3k |
| userPatA | input | 16 | Word emitted for code 3'b110 |
| userPatB | input | 16 | Word emitted for code 3'b111 |
| dataOut | output | 16 | Registered output word |
| patActive | output | 1 | High while pattern words are being emitted |

## Verification
The hardest case to reach is the phase of the alternating code. It must advance only on that code's own emissions, even when other codes are placed between them, and it must restart when pattern mode is re-entered partway through a cycle. To get there, the stimulus sweeps mixed slot layouts in which the alternating code sits next to other codes. It also rewrites slot codes while the pointer is elsewhere. Finally, it leaves pattern mode at an odd phase and enters it again. Expected words come from a pointer and phase model kept in the bench.

// File: rtl/tpseq_pkg.sv
package tpseq_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    PAT_ZERO = 3'b000,
    PAT_ONES = 3'b001,
    PAT_ALT  = 3'b010,
    PAT_AAAA = 3'b011,
    PAT_5555 = 3'b100,
    PAT_A5A5 = 3'b101,
    PAT_USR0 = 3'b110,
    PAT_USR1 = 3'b111
  } tpCode_t;

  typedef struct packed {
    logic    emit;     // pattern mode: emit a pattern word this cycle
    tpCode_t code;     // code of the slot under the pointer
    logic    altHigh;  // phase of the alternating pattern
  } tpCtl_t;
endpackage

// File: rtl/tpseq_ctrl.sv
module tpseq_ctrl
  import tpseq_pkg::*;
#(
  parameter int NSLOT = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [1:0]              modeSel,
  input  logic [NSLOT*CODE_W-1:0] slotCodes,
  output tpCtl_t                  ctl
);
  localparam int PTR_W = $clog2(NSLOT);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NSLOT - 1);

  logic [PTR_W-1:0] ptr;
  logic             altHigh;
  logic             patMode;

  assign patMode = (modeSel == 2'b11);

  always_comb begin
    ctl.emit    = patMode;
    ctl.code    = tpCode_t'(slotCodes[ptr*CODE_W +: CODE_W]);
    ctl.altHigh = altHigh;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !patMode) begin
      ptr     <= '0;
      altHigh <= 1'b1;
    end else begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      if (ctl.code == PAT_ALT) altHigh <= ~altHigh;
    end
  end

  AST_ALT_PHASE_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.emit && ctl.code == PAT_ALT) |=> (!ctl.emit || ctl.altHigh != $past(ctl.altHigh))); // R6

  AST_ALT_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.emit |=> ctl.altHigh); // R10
endmodule

// File: rtl/tpseq_datapath.sv
module tpseq_datapath
  import tpseq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  tpCtl_t       ctl,
  input  logic [W-1:0] sampleIn,
  input  logic [W-1:0] userPatA,
  input  logic [W-1:0] userPatB,
  output logic [W-1:0] dataOut,
  output logic         patActive
);
  localparam logic [W-1:0] WORD_AAAA = {(W/2){2'b10}};
  localparam logic [W-1:0] WORD_5555 = {(W/2){2'b01}};
  localparam logic [W-1:0] WORD_A5A5 = {(W/8){8'hA5}};

  logic [W-1:0] patWord;

  always_comb begin
    case (ctl.code)
      PAT_ZERO: patWord = '0;
      PAT_ONES: patWord = '1;
      PAT_ALT:  patWord = ctl.altHigh ? '1 : '0;
      PAT_AAAA: patWord = WORD_AAAA;
      PAT_5555: patWord = WORD_5555;
      PAT_A5A5: patWord = WORD_A5A5;
      PAT_USR0: patWord = userPatA;
      default:  patWord = userPatB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut   <= '0;
      patActive <= 1'b0;
    end else begin
      dataOut   <= ctl.emit ? patWord : sampleIn;
      patActive <= ctl.emit;
    end
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.emit |=> (dataOut == $past(sampleIn) && !patActive)); // R2

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    ctl.emit |=> patActive); // R3

  AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.emit && ctl.code == PAT_ZERO) |=> dataOut == '0); // R5

  AST_USER_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.emit && ctl.code == PAT_USR0) |=> dataOut == $past(userPatA)); // R7
endmodule

// File: rtl/tpseq_top.sv
module tpseq_top
  import tpseq_pkg::*;
#(
  parameter int W     = 16,
  parameter int NSLOT = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [1:0]              modeSel,
  input  logic [W-1:0]            sampleIn,
  input  logic [NSLOT*CODE_W-1:0] slotCodes,
  input  logic [W-1:0]            userPatA,
  input  logic [W-1:0]            userPatB,
  output logic [W-1:0]            dataOut,
  output logic                    patActive
);
  tpCtl_t ctl;

  tpseq_ctrl #(.NSLOT(NSLOT)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .slotCodes(slotCodes), .ctl(ctl)
  );

  tpseq_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleIn(sampleIn),
    .userPatA(userPatA), .userPatB(userPatB),
    .dataOut(dataOut), .patActive(patActive)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> (dataOut == '0 && !patActive)); // R1
endmodule

// File: tb/tpseq_top_bench.sv
module tpseq_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic [15:0] sampleIn = '0;
  logic [23:0] slotCodes = 24'o22222222;
  logic [15:0] userPatA = '0;
  logic [15:0] userPatB = '0;
  logic [15:0] dataOut;
  logic        patActive;

  int nTests = 0;
  int nFails = 0;
  int ptrExp = 0;
  bit altExp = 1'b1;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tpseq_top u_tpseq_top (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .sampleIn(sampleIn),
    .slotCodes(slotCodes), .userPatA(userPatA), .userPatB(userPatB),
    .dataOut(dataOut), .patActive(patActive)
  );

  function automatic logic [15:0] wordOf(input logic [2:0] c, input bit alt);
    case (c)
      3'd0: wordOf = 16'h0000;
      3'd1: wordOf = 16'hFFFF;
      3'd2: wordOf = alt ? 16'hFFFF : 16'h0000;
      3'd3: wordOf = 16'hAAAA;
      3'd4: wordOf = 16'h5555;
      3'd5: wordOf = 16'hA5A5;
      3'd6: wordOf = userPatA;
      default: wordOf = userPatB;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a negedge with inputs already set; checks after the next posedge.
  task automatic cyc(input string req);
    logic [15:0] expWord;
    logic        expFlag;
    if (modeSel == 2'b11) begin
      logic [2:0] c;
      c = slotCodes[ptrExp*3 +: 3];
      expWord = wordOf(c, altExp);
      if (c == 3'd2) altExp = ~altExp;
      ptrExp = (ptrExp + 1) % 8;
      expFlag = 1'b1;
    end else begin
      expWord = sampleIn;
      expFlag = 1'b0;
      ptrExp = 0;
      altExp = 1'b1;
    end
    @(posedge clk);
    #1;
    check(req, dataOut, expWord);
    check(req, {15'd0, patActive}, {15'd0, expFlag});
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", dataOut, 16'h0000);
    check("R1", {15'd0, patActive}, 16'd0);
    rstN = 1'b1;

    // R2: passthrough with several modes that are not pattern mode
    for (int i = 0; i < 12; i++) begin
      modeSel = 2'(i % 3);
      sampleIn = 16'(i * 16'h1357 + 16'h0F0F);
      cyc("R2");
    end

    // R6: default slots alternate ones and zeros
    userPatA = 16'h1234; userPatB = 16'hBEEF;
    modeSel = 2'b11;
    for (int i = 0; i < 12; i++) cyc("R6 R3");

    // R5 R7: every code in every slot
    for (int c = 0; c < 8; c++) begin
      modeSel = 2'b00; cyc("R2");
      slotCodes = {8{3'(c)}};
      modeSel = 2'b11;
      for (int i = 0; i < 10; i++) cyc((c >= 6) ? "R7" : "R5");
    end

    // R4 R8: distinct code per slot, slot k holds code k
    modeSel = 2'b00; cyc("R2");
    for (int k = 0; k < 8; k++) slotCodes[k*3 +: 3] = 3'(k);
    modeSel = 2'b11;
    for (int i = 0; i < 20; i++) cyc("R4 R8");

    // R6: mixed layouts with the alternating code between others
    for (int s = 0; s < 6; s++) begin
      modeSel = 2'b00; cyc("R10");
      for (int k = 0; k < 8; k++) slotCodes[k*3 +: 3] = 3'((k * (s + 3) + s) % 8);
      modeSel = 2'b11;
      for (int i = 0; i < 17; i++) cyc("R6 R4");
    end

    // R9: rewrite slots and user words mid-run
    for (int i = 0; i < 24; i++) begin
      slotCodes[((i + 4) % 8)*3 +: 3] = 3'((i * 5) % 8);
      userPatA = 16'(i * 16'h0101 + 16'h00A0);
      userPatB = ~userPatA;
      cyc("R9");
    end

    // R10: leave at an odd phase and re-enter
    slotCodes = 24'o22222222;
    for (int r = 1; r < 6; r++) begin
      for (int i = 0; i < r; i++) cyc("R10");
      modeSel = 2'b01; sampleIn = 16'(r); cyc("R2");
      modeSel = 2'b11;
      cyc("R10");
    end

    // R1: reset in the middle of pattern mode
    rstN = 1'b0;
    @(posedge clk); #1;
    check("R1", dataOut, 16'h0000);
    check("R1", {15'd0, patActive}, 16'd0);
    @(negedge clk);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end
endmodule